// File: doc/BRIEF.md
# Successive Approximation Conversion Timer

This block paces one analog-to-digital conversion from the bus clock. A programmable even divider produces a slower conversion clock. Each conversion starts with a two-phase sample window: a fixed part of two conversion clocks, then a part of 2, 4, 8 or 16 conversion clocks. After the sample window comes a bit-serial binary search. The block drives a trial code to an external DAC and reads back one comparator bit for each trial.

The comparator, the DAC and the sample capacitor are outside the block. The block reports a 10-bit or an 8-bit code with a single-cycle completion pulse. Any configuration write cancels a conversion that is in progress. A new start request may then follow at any time.

Top module: `sar_conv_timer`

## Requirements
- R1: Each conversion clock lasts 2×(prs+1) bus cycles. prs is a 5-bit value, so the divisor runs from 2 to 64. The divider value, the sample code and the resolution are all captured in the cycle that `start` is accepted, and the divider restarts from zero in that cycle.
- R2: `done` goes high exactly 2×(prs+1)×(N+S+2) bus cycles after the clock edge that accepts `start`. N is 10 when `res8`=0 and 8 when `res8`=1. S comes from `smp_code`: 00 gives 2, 01 gives 4, 10 gives 8 and 11 gives 16.
- R3: The trial code is cleared on start, and `dac_code` reads 0 for the whole sample window. The sample window lasts 2+S conversion clocks.
- R4: The first trial begins right after the sample window. At that point `dac_code` holds only the top bit: 512 in 10-bit mode, 128 in 8-bit mode.
- R5: The comparator input `cmp_gt` is 1 when the DAC output is above the analog input. After each trial the tried bit is cleared when `cmp_gt`=1 and kept otherwise. The bits are tried from the top bit down to bit 0, so an ideal comparison against input value v gives `result` = v in 10-bit mode.
- R6: In 8-bit mode the code sits in `result[7:0]`, and bits [9:8] of `result` and of `dac_code` stay 0. An input above 255 yields 255.
- R7: `done` is high for exactly one bus cycle. `busy` is high from the cycle after start until the cycle before `done`, and `busy` is low while `done` is high.
- R8: `result` changes only in the cycle where `done` is high. It keeps its value through a later start, through the whole sampling and search, and through an abort.
- R9: A `cfg_wr` pulse cancels any conversion in progress: `busy` is low in the next cycle, no `done` follows, and `result` is unchanged. When `cfg_wr` and `start` are high in the same cycle, `cfg_wr` wins and no conversion begins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe; aborts a running conversion |
| prs | input | 5 | Divider value; the conversion clock is the bus clock / (2×(prs+1)) |
| smp_code | input | 2 | Length code for the second sample phase |
| res8 | input | 1 | 1 selects 8-bit, 0 selects 10-bit |
| start | input | 1 | Begin a conversion (restarts if one is running) |
| cmp_gt | input | 1 | Comparator: DAC output is greater than the analog input |
| dac_code | output | 10 | Trial code presented to the DAC |
| busy | output | 1 | Conversion in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 10 | Last completed conversion code |

## Verification
Every 10-bit input code from 0 to 1023 is converted with the fastest divider and the shortest sample window. A wrong decision at any bit position, or a search in the wrong order, gives at least one mismatching code in this sweep.

All 8-bit codes are converted as well, together with a few inputs above 255. These tell whether the search starts from the right top bit and whether it saturates correctly.

A timing sweep covers three divider values, all four sample codes and both resolutions. The measured start-to-done latency separates divider errors, phase length errors and bit-count errors from one another. Aborts are issued during sampling, during the search and in the same cycle as start, which shows whether a configuration write cancels the conversion cleanly.

// File: rtl/sar_pkg.sv
package sar_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SMP1 = 2'd1,
    ST_SMP2 = 2'd2,
    ST_CONV = 2'd3
  } sar_state_t;

  localparam int SMP1_CLKS = 2;

endpackage

// File: rtl/sar_clk_div.sv
module sar_clk_div #(
  parameter int PRS_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             restart,
  input  logic [PRS_W-1:0] div_sel,
  output logic             tick
);

  localparam int CNT_W = PRS_W + 1;

  logic [CNT_W-1:0] cnt_q, cnt_n;

  // terminal count is 2*(div_sel+1)-1 = {div_sel,1}
  assign tick = run && !restart && (cnt_q == {div_sel, 1'b1});

  always_comb begin
    cnt_n = cnt_q;
    if (restart || !run) begin
      cnt_n = '0;
    end else if (tick) begin
      cnt_n = '0;
    end else begin
      cnt_n = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_n;
    end
  end

  // R1: conversion clock period is at least two bus cycles
  assert_tick_spacing_R1: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);

endmodule

// File: rtl/sar_seq.sv
module sar_seq
  import sar_pkg::*;
#(
  parameter int RES_HI = 10,
  parameter int RES_LO = 8,
  parameter int SMP_W  = 2,
  parameter int BIT_W  = $clog2(RES_HI)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             abort,
  input  logic             tick,
  input  logic [SMP_W-1:0] smp_code,
  input  logic             res8,
  output logic             busy,
  output logic             done,
  output logic             sar_clear,
  output logic             sar_load,
  output logic             sar_step,
  output logic [BIT_W-1:0] bit_idx
);

  localparam int PH_W = (1 << SMP_W) + 1;

  sar_state_t       state_q, state_n;
  logic [PH_W-1:0]  ph_q, ph_n;
  logic [BIT_W-1:0] bit_q, bit_n;
  logic             done_q, done_n;
  logic [PH_W-1:0]  smp_last;
  logic             adv;

  assign smp_last = (PH_W'(2) << smp_code) - PH_W'(1);
  assign adv      = tick && !abort && !start;

  always_comb begin
    state_n = state_q;
    ph_n    = ph_q;
    bit_n   = bit_q;
    done_n  = 1'b0;
    if (abort) begin
      state_n = ST_IDLE;
      ph_n    = '0;
    end else if (start) begin
      state_n = ST_SMP1;
      ph_n    = '0;
    end else if (tick) begin
      case (state_q)
        ST_SMP1: begin
          if (ph_q == PH_W'(SMP1_CLKS - 1)) begin
            state_n = ST_SMP2;
            ph_n    = '0;
          end else begin
            ph_n = ph_q + PH_W'(1);
          end
        end
        ST_SMP2: begin
          if (ph_q == smp_last) begin
            state_n = ST_CONV;
            ph_n    = '0;
            bit_n   = res8 ? BIT_W'(RES_LO - 1) : BIT_W'(RES_HI - 1);
          end else begin
            ph_n = ph_q + PH_W'(1);
          end
        end
        ST_CONV: begin
          if (bit_q == '0) begin
            state_n = ST_IDLE;
            done_n  = 1'b1;
          end else begin
            bit_n = bit_q - BIT_W'(1);
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ph_q    <= '0;
      bit_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_n;
      ph_q    <= ph_n;
      bit_q   <= bit_n;
      done_q  <= done_n;
    end
  end

  assign busy      = (state_q != ST_IDLE);
  assign done      = done_q;
  assign sar_clear = start && !abort;
  assign sar_load  = adv && (state_q == ST_SMP2) && (ph_q == smp_last);
  assign sar_step  = adv && (state_q == ST_CONV);
  assign bit_idx   = bit_q;

  // R7: completion pulse is a single bus cycle
  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R7: busy is low while done is reported
  assert_done_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R9: configuration write leaves the block idle with no completion
  assert_abort_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> (!busy && !done));

endmodule

// File: rtl/sar_reg.sv
module sar_reg #(
  parameter int RES_HI = 10,
  parameter int BIT_W  = $clog2(RES_HI)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              load,
  input  logic              step,
  input  logic [BIT_W-1:0]  load_idx,
  input  logic [BIT_W-1:0]  bit_idx,
  input  logic              cmp_gt,
  output logic [RES_HI-1:0] trial,
  output logic [RES_HI-1:0] result
);

  logic [RES_HI-1:0] sar_q, sar_n;
  logic [RES_HI-1:0] res_q, res_n;

  always_comb begin
    sar_n = sar_q;
    res_n = res_q;
    if (clear) begin
      sar_n = '0;
    end else if (load) begin
      sar_n           = '0;
      sar_n[load_idx] = 1'b1;
    end else if (step) begin
      if (cmp_gt) begin
        sar_n[bit_idx] = 1'b0;
      end
      if (bit_idx != '0) begin
        sar_n[bit_idx - BIT_W'(1)] = 1'b1;
      end else begin
        res_n = sar_n;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sar_q <= '0;
      res_q <= '0;
    end else begin
      sar_q <= sar_n;
      res_q <= res_n;
    end
  end

  assign trial  = sar_q;
  assign result = res_q;

  // R4: a fresh search holds exactly one set bit
  assert_load_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> $onehot0(trial) && (trial != '0));

endmodule

// File: rtl/sar_conv_timer.sv
module sar_conv_timer #(
  parameter int RES_HI = 10,
  parameter int RES_LO = 8,
  parameter int PRS_W  = 5,
  parameter int SMP_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [PRS_W-1:0]  prs,
  input  logic [SMP_W-1:0]  smp_code,
  input  logic              res8,
  input  logic              start,
  input  logic              cmp_gt,
  output logic [RES_HI-1:0] dac_code,
  output logic              busy,
  output logic              done,
  output logic [RES_HI-1:0] result
);

  localparam int BIT_W = $clog2(RES_HI);

  logic             start_acc;
  logic [PRS_W-1:0] prs_q;
  logic [SMP_W-1:0] smp_q;
  logic             res8_q;
  logic             tick;
  logic             sar_clear, sar_load, sar_step;
  logic [BIT_W-1:0] bit_idx, load_idx;

  assign start_acc = start && !cfg_wr;
  assign load_idx  = res8_q ? BIT_W'(RES_LO - 1) : BIT_W'(RES_HI - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prs_q  <= '0;
      smp_q  <= '0;
      res8_q <= 1'b0;
    end else if (start_acc) begin
      prs_q  <= prs;
      smp_q  <= smp_code;
      res8_q <= res8;
    end
  end

  sar_clk_div #(.PRS_W(PRS_W)) i_div (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (busy),
    .restart (start_acc),
    .div_sel (prs_q),
    .tick    (tick)
  );

  sar_seq #(.RES_HI(RES_HI), .RES_LO(RES_LO), .SMP_W(SMP_W), .BIT_W(BIT_W)) i_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start_acc),
    .abort     (cfg_wr),
    .tick      (tick),
    .smp_code  (smp_q),
    .res8      (res8_q),
    .busy      (busy),
    .done      (done),
    .sar_clear (sar_clear),
    .sar_load  (sar_load),
    .sar_step  (sar_step),
    .bit_idx   (bit_idx)
  );

  sar_reg #(.RES_HI(RES_HI), .BIT_W(BIT_W)) i_reg (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (sar_clear),
    .load     (sar_load),
    .step     (sar_step),
    .load_idx (load_idx),
    .bit_idx  (bit_idx),
    .cmp_gt   (cmp_gt),
    .trial    (dac_code),
    .result   (result)
  );

  // R3: trial code is zero when a conversion begins
  assert_clear_on_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (dac_code == '0));

  // R8: result moves only together with the completion pulse
  assert_result_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(result) |-> done);

  // R6: 8-bit mode keeps the upper code bits clear
  assert_res8_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (res8_q && (busy || done)) |-> (dac_code[RES_HI-1:RES_LO] == '0));

endmodule

// File: tb/test_sar_conv_timer.sv
module test_sar_conv_timer;

  logic       clk;
  logic       rst_n;
  logic       cfg_wr;
  logic [4:0] prs;
  logic [1:0] smp_code;
  logic       res8;
  logic       start;
  logic       cmp_gt;
  logic [9:0] dac_code;
  logic       busy;
  logic       done;
  logic [9:0] result;
  logic [9:0] vin;

  int checks = 0;
  int errors = 0;

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // ideal comparator: high when DAC output is above the input
  assign cmp_gt = (dac_code > vin);

  sar_conv_timer i_sar_conv_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_wr   (cfg_wr),
    .prs      (prs),
    .smp_code (smp_code),
    .res8     (res8),
    .start    (start),
    .cmp_gt   (cmp_gt),
    .dac_code (dac_code),
    .busy     (busy),
    .done     (done),
    .result   (result)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic conv(input int p, input int s, input bit r8, input int v);
    int d, tt, n, n_msb, ex_res, slen;
    bit hold_ok;
    logic [9:0] prev;
    slen   = 2 << s;
    d      = 2 * (p + 1);
    tt     = (r8 ? 8 : 10) + slen + 2;
    n_msb  = d * (2 + slen);
    ex_res = r8 ? ((v > 255) ? 255 : v) : v;
    @(negedge clk);
    prs      = p[4:0];
    smp_code = s[1:0];
    res8     = r8;
    vin      = v[9:0];
    start    = 1'b1;
    prev     = result;
    @(posedge clk);
    @(negedge clk);
    start   = 1'b0;
    n       = 0;
    hold_ok = 1'b1;
    while (n < 4000) begin
      @(posedge clk);
      n++;
      @(negedge clk);
      if (n == n_msb - 1) chk(dac_code == 10'd0, "R3 code clear in sample", int'(dac_code), 0);
      if (n == n_msb) chk(dac_code == (r8 ? 10'd128 : 10'd512), "R4 first trial",
                          int'(dac_code), r8 ? 128 : 512);
      if (done) break;
      if (result !== prev) hold_ok = 1'b0;
      if (!busy) hold_ok = 1'b0;
    end
    chk(n == d * tt, "R1 R2 conversion latency", n, d * tt);
    if (r8) chk(result == 10'(ex_res), "R6 8-bit result", int'(result), ex_res);
    else    chk(result == 10'(ex_res), "R5 10-bit result", int'(result), ex_res);
    chk(hold_ok, "R8 result held and busy during conversion", int'(hold_ok), 1);
    chk(busy == 1'b0, "R7 busy low at done", int'(busy), 0);
    @(negedge clk);
    chk(done == 1'b0, "R7 done width", int'(done), 0);
  endtask

  task automatic abort_at(input int cyc);
    logic [9:0] prev;
    int seen;
    prev = result;
    @(negedge clk);
    prs = 5'd1; smp_code = 2'd1; res8 = 1'b0; vin = 10'd77; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (cyc) @(negedge clk);
    cfg_wr = 1'b1;
    @(negedge clk);
    cfg_wr = 1'b0;
    chk(busy == 1'b0, "R9 busy low after abort", int'(busy), 0);
    seen = 0;
    repeat (300) begin
      @(negedge clk);
      if (done) seen++;
    end
    chk(seen == 0, "R9 no done after abort", seen, 0);
    chk(result == prev, "R9 result kept after abort", int'(result), int'(prev));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL R2 watchdog expired: actual 190000 cycles expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [9:0] keep;
    rst_n = 1'b0; cfg_wr = 1'b0; prs = '0; smp_code = '0; res8 = 1'b0;
    start = 1'b0; vin = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(busy == 1'b0, "R7 reset busy", int'(busy), 0);
    chk(done == 1'b0, "R7 reset done", int'(done), 0);
    chk(result == 10'd0, "R8 reset result", int'(result), 0);
    chk(dac_code == 10'd0, "R3 reset code", int'(dac_code), 0);
    rst_n = 1'b1;

    for (int v = 0; v < 1024; v++) conv(0, 0, 1'b0, v);
    for (int v = 0; v < 256; v++) conv(0, 0, 1'b1, v);
    conv(0, 0, 1'b1, 256);
    conv(0, 0, 1'b1, 700);
    conv(0, 0, 1'b1, 1023);

    for (int pi = 0; pi < 3; pi++) begin
      for (int s = 0; s < 4; s++) begin
        for (int r = 0; r < 2; r++) begin
          conv((pi == 0) ? 0 : ((pi == 1) ? 3 : 31), s, r[0], 345 + s);
        end
      end
    end

    conv(2, 1, 1'b0, 345);
    abort_at(5);
    abort_at(29);

    keep = result;
    @(negedge clk);
    vin = 10'd900; cfg_wr = 1'b1; start = 1'b1;
    @(negedge clk);
    cfg_wr = 1'b0; start = 1'b0;
    chk(busy == 1'b0, "R9 write beats start", int'(busy), 0);
    repeat (100) @(negedge clk);
    chk(result == keep, "R9 no conversion after write with start", int'(result), int'(keep));

    conv(0, 0, 1'b0, 600);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule